// File: doc/BRIEF.md
# Page Write Collector with Timed Commit

This block sits between a two-wire bus slave and a byte-wide nonvolatile array. During a write transaction it gathers incoming data bytes into a 16-slot page buffer. The page is chosen by the first byte's address. When the transaction ends with a stop, it copies the received bytes into the array and then holds a busy flag for a fixed number of clocks, standing in for the self-timed programming time of the cells.

The bus slave uses `busy` to withhold acknowledges. A host can therefore poll with a start and a write header until it is acknowledged again. A transaction that is abandoned with a new start, or that ends with no data, leaves the array and `busy` alone. The block also keeps the current-address pointer that a following read without an address would use.

Top module: `page_commit`

## Requirements
- R1: After reset `busy` is 0, `arr_we` is 0 and `cur_addr` is 0.
- R2: The first byte of a transaction takes its page (address bits 10..4) and its slot (bits 3..0) from `wr_addr`. Later bytes of the same transaction ignore `wr_addr` and go to the next slot of that page.
- R3: The slot number wraps from 15 to 0 within the page. A byte that lands on a slot already filled replaces it, and only the last value is committed.
- R4: A stop that arrives while idle, with at least one byte buffered, raises `busy` on the next cycle. `busy` then stays high for exactly CYCLE_CLKS cycles.
- R5: During commit, the array is written only in the first 16 busy cycles, at most one byte per clock, in ascending slot order. Only slots received in this transaction are written, to address {page, slot}. `arr_we` is never high while `busy` is low.
- R6: A stop with no byte buffered writes nothing and leaves `busy` low.
- R7: A start strobe discards every byte buffered so far, and a later stop commits only bytes that arrive after it.
- R8: While `busy` is high, the byte, start and stop strobes have no effect: `cur_addr` does not change and no extra write or busy period follows.
- R9: After each accepted byte, `cur_addr` equals {page, (slot+1) mod 16}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| txn_start | input | 1 | Start-condition strobe, one cycle |
| wr_stb | input | 1 | Received data byte strobe |
| wr_addr | input | 11 | Byte address (used on first byte) |
| wr_data | input | 8 | Received data byte |
| stop_stb | input | 1 | Stop-condition strobe, one cycle |
| arr_we | output | 1 | Array write enable |
| arr_addr | output | 11 | Array write address |
| arr_data | output | 8 | Array write data |
| busy | output | 1 | Internal write cycle in progress |
| cur_addr | output | 11 | Current-address pointer |

## Verification
The bench runs several kinds of transaction. A single byte shows that page and slot are taken from the first address. A short page run that starts mid-page shows the slot order. An 18-byte run that wraps past slot 15 shows that the overwritten slots commit only their last value. Empty and abandoned transactions (a stop with no data, and a start followed by a second start) show that nothing is committed from discarded data. Strobes injected in the middle of a busy period show that the lockout ignores them. Each busy window is measured in cycles and compared with the parameter.

// File: rtl/page_commit.sv
module page_commit #(
  parameter int ADDR_W     = 11,
  parameter int DATA_W     = 8,
  parameter int PAGE_BITS  = 4,
  parameter int CYCLE_CLKS = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_start,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stop_stb,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_addr,
  output logic [DATA_W-1:0] arr_data,
  output logic              busy,
  output logic [ADDR_W-1:0] cur_addr
);
  localparam int PAGE_SZ = 1 << PAGE_BITS;
  localparam int HI_W    = ADDR_W - PAGE_BITS;
  localparam int CNT_W   = $clog2(CYCLE_CLKS + 1);

  logic [DATA_W-1:0]    buf_q [PAGE_SZ];
  logic [PAGE_SZ-1:0]   vmask_q;
  logic [HI_W-1:0]      page_q;
  logic [PAGE_BITS-1:0] ofs_q;
  logic                 busy_q;
  logic [CNT_W-1:0]     cnt_q;
  logic [ADDR_W-1:0]    cur_q;

  wire                 first   = ~|vmask_q;
  wire                 accept  = wr_stb && !busy_q && !txn_start;
  wire [PAGE_BITS-1:0] wr_slot = first ? wr_addr[PAGE_BITS-1:0] : ofs_q;
  wire [HI_W-1:0]      hi_sel  = first ? wr_addr[ADDR_W-1:PAGE_BITS] : page_q;
  wire [PAGE_BITS-1:0] nxt_slot = wr_slot + 1'b1;
  wire [PAGE_BITS-1:0] scan    = cnt_q[PAGE_BITS-1:0];
  wire                 in_scan = busy_q && (cnt_q < CNT_W'(PAGE_SZ));
  wire                 last_clk = (cnt_q == CNT_W'(CYCLE_CLKS - 1));

  assign arr_we   = in_scan && vmask_q[scan];
  assign arr_addr = {page_q, scan};
  assign arr_data = buf_q[scan];
  assign busy     = busy_q;
  assign cur_addr = cur_q;

  always_ff @(posedge clk) begin
    if (accept) buf_q[wr_slot] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vmask_q <= '0;
      page_q  <= '0;
      ofs_q   <= '0;
      busy_q  <= 1'b0;
      cnt_q   <= '0;
      cur_q   <= '0;
    end else if (busy_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (last_clk) begin
        busy_q  <= 1'b0;
        cnt_q   <= '0;
        vmask_q <= '0;
      end
    end else if (txn_start) begin
      vmask_q <= '0;
    end else if (stop_stb) begin
      if (!first) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end
    end else if (accept) begin
      vmask_q[wr_slot] <= 1'b1;
      page_q <= hi_sel;
      ofs_q  <= nxt_slot;
      cur_q  <= {hi_sel, nxt_slot};
    end
  end

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (!busy && !arr_we && cur_addr == '0)); // R1
  AST_WE_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) arr_we |-> busy); // R5
  AST_STOP_COMMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !txn_start && stop_stb && |vmask_q) |=> busy); // R4
  AST_EMPTY_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && stop_stb && vmask_q == '0) |=> !busy); // R6
  AST_START_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && txn_start) |=> vmask_q == '0); // R7
  AST_LOCKOUT_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(cur_addr)); // R8
  AST_SLOT_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !first && ofs_q == '1) |=> cur_addr[PAGE_BITS-1:0] == '0); // R3
endmodule

// File: tb/page_commit_test.sv
module page_commit_test;
  localparam int CYC = 40;
  logic clk = 0, rst_n = 0;
  logic txn_start = 0, wr_stb = 0, stop_stb = 0;
  logic [10:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic arr_we, busy;
  logic [10:0] arr_addr, cur_addr;
  logic [7:0] arr_data;

  page_commit #(.CYCLE_CLKS(CYC)) uut (
    .clk(clk), .rst_n(rst_n), .txn_start(txn_start), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .stop_stb(stop_stb),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_data(arr_data),
    .busy(busy), .cur_addr(cur_addr));

  always #2.5 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  logic [18:0] exp_q[$];
  logic [7:0] m_buf [16];
  logic [15:0] m_val = '0;
  logic [6:0] m_page = '0;
  logic [3:0] m_ofs = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && arr_we) begin
      if (exp_q.size() == 0) chk(0, "R5 unexpected array write", {arr_addr, arr_data}, 0);
      else begin
        logic [18:0] e;
        e = exp_q.pop_front();
        chk({arr_addr, arr_data} == e, "R5 array write", {arr_addr, arr_data}, e);
      end
    end
  end

  task automatic pulse_start();
    txn_start = 1; @(posedge clk); #1 txn_start = 0;
    m_val = '0;
  endtask

  task automatic put_byte(input logic [10:0] a, input logic [7:0] d);
    wr_stb = 1; wr_addr = a; wr_data = d;
    @(posedge clk); #1 wr_stb = 0;
    if (m_val == 0) begin m_page = a[10:4]; m_ofs = a[3:0]; end
    m_buf[m_ofs] = d; m_val[m_ofs] = 1'b1; m_ofs = m_ofs + 1;
    chk(cur_addr == {m_page, m_ofs}, "R9 cur_addr after byte", cur_addr, {m_page, m_ofs});
  endtask

  task automatic do_stop(input bit junk);
    int n;
    logic [10:0] ca;
    bit commit;
    commit = (m_val != 0);
    for (int s = 0; s < 16; s++)
      if (m_val[s]) exp_q.push_back({m_page, 4'(s), m_buf[s]});
    stop_stb = 1; @(posedge clk); #1 stop_stb = 0;
    ca = cur_addr;
    n = 0;
    for (int k = 0; k < CYC + 20; k++) begin
      if (!busy) break;
      n++;
      if (junk && n == 3) begin
        wr_stb = 1; wr_addr = 11'h555; wr_data = 8'hEE;
      end
      if (junk && n == 5) txn_start = 1;
      if (junk && n == 7) stop_stb = 1;
      @(posedge clk); #1;
      wr_stb = 0; txn_start = 0; stop_stb = 0;
    end
    if (commit) chk(n == CYC, "R4 busy length", n, CYC);
    else chk(n == 0, "R6/R7 no busy without data", n, 0);
    chk(exp_q.size() == 0, "R5 all expected writes seen", exp_q.size(), 0);
    if (junk) chk(cur_addr == ca, "R8 cur_addr held during busy", cur_addr, ca);
    m_val = '0;
  endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(!busy && !arr_we && cur_addr == 0, "R1 reset state", {busy, arr_we, cur_addr}, 0);
    rst_n = 1;
    @(posedge clk); #1;

    // R2 single byte
    pulse_start(); put_byte(11'h123, 8'hA5); do_stop(0);
    // R2 page run mid-page; later addresses ignored
    pulse_start(); put_byte(11'h3FA, 8'h11);
    put_byte(11'h000, 8'h22); put_byte(11'h7FF, 8'h33);
    put_byte(11'h0A0, 8'h44); put_byte(11'h3FA, 8'h55); do_stop(0);
    // R3 wrap: 18 bytes from slot 14
    pulse_start();
    for (int i = 0; i < 18; i++) put_byte(11'h70E, 8'(8'h80 + i));
    do_stop(0);
    // R6 empty stop
    pulse_start(); do_stop(0);
    // R7 abandoned then empty
    pulse_start(); put_byte(11'h040, 8'h99); put_byte(11'h040, 8'h98);
    pulse_start(); do_stop(0);
    // R7 abandoned then new data
    pulse_start(); put_byte(11'h2C3, 8'h01);
    pulse_start(); put_byte(11'h5B7, 8'hC3); do_stop(0);
    // R8 junk strobes during busy
    pulse_start(); put_byte(11'h60F, 8'h7E); put_byte(11'h000, 8'h7F); do_stop(1);
    do_stop(0);
    chk(!busy, "R8 no extra busy period", busy, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule